// File: doc/BRIEF.md
# Iterative Euler Step Solver with Shared Arithmetic Units

This block advances a second-order differential equation by forward-Euler steps. It starts from an initial position `x`, value `y` and derivative `u`, and repeats the step while `x` stays below the limit `a`. Each step applies three coupled updates: x' = x + dx, y' = y + u*dx and u' = u - 3*x*u*dx - 3*y*dx. All values are 8-bit unsigned and every operation wraps modulo 256.

The datapath has one multiplier that keeps the low 8 bits of its product, one adder/subtractor and one comparator. A controller passes the operations through these units over several states and keeps partial results in temporary registers. The loop comparison is stored in a register before the controller uses it. A caller drives the initial values, the limit and the step, then pulses `start` and waits for `done`. While `done` is high the final state is on the outputs, and it stays there until the next accepted start.

Top module: `diffeq_solver`

## Requirements
- R1: While reset is applied and after it is released, `done` is low and `x_out`, `y_out` and `u_out` read 0.
- R2: In idle with `start` low, the outputs do not change and `done` stays low, whatever the data inputs do.
- R3: Before each step the block checks the current x against the limit with an unsigned compare. A step runs only if x < a. When the initial x is greater than or equal to a, no step runs and the outputs equal the initial values.
- R4: Each step sets x to (x + dx) mod 256.
- R5: Each step sets u to (u - 3*x*u*dx - 3*y*dx) mod 256.
- R6: Each step sets y to (y + u*dx) mod 256.
- R7: All three updates in a step use the values from before that step. x, y and u change together, in one cycle.
- R8: For a run of n steps, `done` is first high in the cycle after the (3 + 9n)-th rising edge, counting the edge that samples `start` as edge 1.
- R9: `done` is high for exactly one cycle. The final x, y and u stay on the outputs until the next start is accepted.
- R10: While a run is in progress, `start` and changes on the data inputs have no effect on its result.
- R11: The loop condition is stored in a register, so the controller acts on it one cycle after the compare.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a run; sampled only in idle |
| a_lim | input | 8 | Loop limit a |
| step | input | 8 | Step size dx |
| x_init | input | 8 | Initial x |
| y_init | input | 8 | Initial y |
| u_init | input | 8 | Initial u |
| x_out | output | 8 | Current and final x |
| y_out | output | 8 | Current and final y |
| u_out | output | 8 | Current and final u |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The assertions check the cycle-level behaviour of the controller on every cycle. They check that the stored condition matches the compare of the previous cycle and that the decision state branches on it. They check that the state registers change only at the commit or when a run is loaded, that x advances by exactly the stored step at each commit, that `done` is a single-cycle pulse and that it fires only once x is no longer below the limit. Only the bench scenarios can show that y and u come out of the shared-unit schedule with the right values for the whole coupled recurrence. The same holds for wraparound, the unsigned compare against a limit above 127, the exact run latency, and a stray start pulse during a run leaving the result unchanged.

// File: rtl/diffeq_pkg.sv
package diffeq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CMP,
    ST_DECIDE,
    ST_P_UD,
    ST_P_XUD,
    ST_P_3XUD,
    ST_P_YD,
    ST_P_3YD,
    ST_U_FIX,
    ST_COMMIT,
    ST_FIN
  } st_e;

  typedef enum logic [2:0] { MA_U, MA_X, MA_Y, MA_TA, MA_TB } mula_e;
  typedef enum logic [1:0] { MB_DX, MB_TA, MB_K3 } mulb_e;
  typedef enum logic [1:0] { AA_X, AA_Y, AA_U, AA_U1 } adda_e;
  typedef enum logic [1:0] { AB_DX, AB_TA, AB_TB } addb_e;

  typedef struct packed {
    logic  load;
    logic  cmp;
    logic  commit;
    mula_e mul_a;
    mulb_e mul_b;
    logic  ta_en;
    logic  tb_en;
    adda_e add_a;
    addb_e add_b;
    logic  sub;
    logic  x1_en;
    logic  y1_en;
    logic  u1_en;
  } ctl_t;

endpackage

// File: rtl/dq_mul.sv
module dq_mul #(
  parameter int W = 8
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] prod
);
  // low half of the product only; wraps modulo 2**W
  assign prod = W'(op_a * op_b);
endmodule

// File: rtl/dq_addsub.sv
module dq_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         sub,
  output logic [W-1:0] res
);
  always_comb begin
    if (sub) res = op_a - op_b;
    else     res = op_a + op_b;
  end
endmodule

// File: rtl/dq_ctrl.sv
module dq_ctrl
  import diffeq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cond,
  output ctl_t ctl,
  output st_e  state,
  output logic done
);
  st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (start) st_d = ST_CMP;
      ST_CMP:    st_d = ST_DECIDE;
      ST_DECIDE: st_d = cond ? ST_P_UD : ST_FIN;
      ST_P_UD:   st_d = ST_P_XUD;
      ST_P_XUD:  st_d = ST_P_3XUD;
      ST_P_3XUD: st_d = ST_P_YD;
      ST_P_YD:   st_d = ST_P_3YD;
      ST_P_3YD:  st_d = ST_U_FIX;
      ST_U_FIX:  st_d = ST_COMMIT;
      ST_COMMIT: st_d = ST_CMP;
      ST_FIN:    st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // per-state control word for the shared units
  always_comb begin
    ctl = '0;
    ctl.mul_a = MA_U;
    ctl.mul_b = MB_DX;
    ctl.add_a = AA_X;
    ctl.add_b = AB_DX;
    unique case (st_q)
      ST_IDLE:   ctl.load = start;
      ST_CMP:    ctl.cmp  = 1'b1;
      ST_P_UD: begin                       // ta = u*dx
        ctl.mul_a = MA_U;  ctl.mul_b = MB_DX; ctl.ta_en = 1'b1;
      end
      ST_P_XUD: begin                      // tb = x*ta ; y1 = y + ta
        ctl.mul_a = MA_X;  ctl.mul_b = MB_TA; ctl.tb_en = 1'b1;
        ctl.add_a = AA_Y;  ctl.add_b = AB_TA; ctl.y1_en = 1'b1;
      end
      ST_P_3XUD: begin                     // tb = 3*tb ; x1 = x + dx
        ctl.mul_a = MA_TB; ctl.mul_b = MB_K3; ctl.tb_en = 1'b1;
        ctl.add_a = AA_X;  ctl.add_b = AB_DX; ctl.x1_en = 1'b1;
      end
      ST_P_YD: begin                       // ta = y*dx ; u1 = u - tb
        ctl.mul_a = MA_Y;  ctl.mul_b = MB_DX; ctl.ta_en = 1'b1;
        ctl.add_a = AA_U;  ctl.add_b = AB_TB; ctl.sub = 1'b1; ctl.u1_en = 1'b1;
      end
      ST_P_3YD: begin                      // ta = 3*ta
        ctl.mul_a = MA_TA; ctl.mul_b = MB_K3; ctl.ta_en = 1'b1;
      end
      ST_U_FIX: begin                      // u1 = u1 - ta
        ctl.add_a = AA_U1; ctl.add_b = AB_TA; ctl.sub = 1'b1; ctl.u1_en = 1'b1;
      end
      ST_COMMIT: ctl.commit = 1'b1;
      default: ;
    endcase
  end

  assign state = st_q;
  assign done  = (st_q == ST_FIN);
endmodule

// File: rtl/dq_datapath.sv
module dq_datapath
  import diffeq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ctl_t         ctl,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] dx_in,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] u_in,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o,
  output logic [W-1:0] u_o,
  output logic [W-1:0] a_o,
  output logic [W-1:0] dx_o,
  output logic         cond_o
);
  localparam logic [W-1:0] K3 = W'(3);

  logic [W-1:0] a_q, dx_q, x_q, y_q, u_q;
  logic [W-1:0] x1_q, y1_q, u1_q, ta_q, tb_q;
  logic         cond_q;
  logic [W-1:0] m_a, m_b, m_p, s_a, s_b, s_r;

  always_comb begin
    unique case (ctl.mul_a)
      MA_U:    m_a = u_q;
      MA_X:    m_a = x_q;
      MA_Y:    m_a = y_q;
      MA_TA:   m_a = ta_q;
      MA_TB:   m_a = tb_q;
      default: m_a = '0;
    endcase
    unique case (ctl.mul_b)
      MB_DX:   m_b = dx_q;
      MB_TA:   m_b = ta_q;
      MB_K3:   m_b = K3;
      default: m_b = '0;
    endcase
    unique case (ctl.add_a)
      AA_X:    s_a = x_q;
      AA_Y:    s_a = y_q;
      AA_U:    s_a = u_q;
      AA_U1:   s_a = u1_q;
      default: s_a = '0;
    endcase
    unique case (ctl.add_b)
      AB_DX:   s_b = dx_q;
      AB_TA:   s_b = ta_q;
      AB_TB:   s_b = tb_q;
      default: s_b = '0;
    endcase
  end

  dq_mul #(.W(W)) u_mul (.op_a(m_a), .op_b(m_b), .prod(m_p));
  dq_addsub #(.W(W)) u_alu (.op_a(s_a), .op_b(s_b), .sub(ctl.sub), .res(s_r));

  // run parameters, captured at load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      dx_q <= '0;
    end else if (ctl.load) begin
      a_q  <= a_in;
      dx_q <= dx_in;
    end
  end

  // architectural state: loaded at start, updated together at commit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
      u_q <= '0;
    end else if (ctl.load) begin
      x_q <= x_in;
      y_q <= y_in;
      u_q <= u_in;
    end else if (ctl.commit) begin
      x_q <= x1_q;
      y_q <= y1_q;
      u_q <= u1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ta_q <= '0;
      tb_q <= '0;
    end else begin
      if (ctl.ta_en) ta_q <= m_p;
      if (ctl.tb_en) tb_q <= m_p;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x1_q <= '0;
      y1_q <= '0;
      u1_q <= '0;
    end else begin
      if (ctl.x1_en) x1_q <= s_r;
      if (ctl.y1_en) y1_q <= s_r;
      if (ctl.u1_en) u1_q <= s_r;
    end
  end

  // registered loop condition (unsigned compare)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cond_q <= 1'b0;
    else if (ctl.cmp) cond_q <= (x_q < a_q);
  end

  assign x_o    = x_q;
  assign y_o    = y_q;
  assign u_o    = u_q;
  assign a_o    = a_q;
  assign dx_o   = dx_q;
  assign cond_o = cond_q;
endmodule

// File: rtl/diffeq_solver.sv
module diffeq_solver
  import diffeq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] a_lim,
  input  logic [W-1:0] step,
  input  logic [W-1:0] x_init,
  input  logic [W-1:0] y_init,
  input  logic [W-1:0] u_init,
  output logic [W-1:0] x_out,
  output logic [W-1:0] y_out,
  output logic [W-1:0] u_out,
  output logic         done
);
  logic         rst_meta, rst_sync_n;
  ctl_t         ctl;
  st_e          state;
  logic         cond;
  logic [W-1:0] a_hold, step_hold;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  dq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .cond(cond),
    .ctl(ctl), .state(state), .done(done)
  );

  dq_datapath #(.W(W)) u_dp (
    .clk(clk), .rst_n(rst_sync_n), .ctl(ctl),
    .a_in(a_lim), .dx_in(step), .x_in(x_init), .y_in(y_init), .u_in(u_init),
    .x_o(x_out), .y_o(y_out), .u_o(u_out),
    .a_o(a_hold), .dx_o(step_hold), .cond_o(cond)
  );
endmodule

// File: rtl/diffeq_solver_chk.sv
module diffeq_solver_chk
  import diffeq_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         done,
  input st_e          state,
  input logic         cond,
  input logic [W-1:0] x_out,
  input logic [W-1:0] y_out,
  input logic [W-1:0] u_out,
  input logic [W-1:0] a_hold,
  input logic [W-1:0] step_hold
);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_cond_registered: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CMP) |=> (cond == ($past(x_out) < $past(a_hold))));

  a_r3_branch_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DECIDE && cond) |=> (state == ST_P_UD));

  a_r3_branch_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DECIDE && !cond) |=> (state == ST_FIN));

  a_r7_state_only_at_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_COMMIT && !(state == ST_IDLE && start))
      |=> ($stable(x_out) && $stable(y_out) && $stable(u_out)));

  a_r4_x_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COMMIT) |=> (x_out == W'($past(x_out) + $past(step_hold))));

  a_r3_done_limit: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(x_out < a_hold));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !start) |=> (state == ST_IDLE && !done));
endmodule

bind diffeq_solver diffeq_solver_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .start(start), .done(done),
  .state(state), .cond(cond),
  .x_out(x_out), .y_out(y_out), .u_out(u_out),
  .a_hold(a_hold), .step_hold(step_hold)
);

// File: tb/diffeq_solver_bench.sv
`timescale 1ns/1ps
module diffeq_solver_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [7:0] a_lim, step, x_init, y_init, u_init;
  logic [7:0] x_out, y_out, u_out;
  logic       done;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  diffeq_solver u_diffeq_solver (
    .clk(clk), .rst_n(rst_n), .start(start), .a_lim(a_lim), .step(step),
    .x_init(x_init), .y_init(y_init), .u_init(u_init),
    .x_out(x_out), .y_out(y_out), .u_out(u_out), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference recurrence, written from the requirements
  task automatic model(input logic [7:0] x0, y0, u0, a, dx,
                       output logic [7:0] xf, yf, uf, output int n);
    logic [7:0] x, y, u, nx, ny, nu;
    x = x0; y = y0; u = u0; n = 0;
    while (x < a && n < 1000) begin
      nx = x + dx;
      ny = y + u * dx;
      nu = u - 8'd3 * x * u * dx - 8'd3 * y * dx;
      x = nx; y = ny; u = nu; n++;
    end
    xf = x; yf = y; uf = u;
  endtask

  // one run; if poke is set a stray start with other data arrives mid-run
  task automatic run_case(input logic [7:0] x0, y0, u0, a, dx,
                          input string tag, input bit poke);
    logic [7:0] ex, ey, eu;
    int n, cnt;
    model(x0, y0, u0, a, dx, ex, ey, eu, n);
    @(negedge clk);
    x_init = x0; y_init = y0; u_init = u0; a_lim = a; step = dx; start = 1'b1;
    cnt = 0;
    @(posedge clk); cnt++;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      x_init = ~x0; y_init = 8'd77; u_init = 8'd33; a_lim = 8'd255; step = 8'd1;
    end
    while (!done && cnt < 5000) begin
      @(posedge clk); cnt++;
      @(negedge clk);
      start = (poke && (cnt == 5 || cnt == 12));
    end
    start = 1'b0;
    chk(cnt == 3 + 9 * n, "R8", {tag, " latency"}, cnt, 3 + 9 * n);
    chk(x_out == ex, "R4", {tag, " x"}, x_out, ex);
    chk(y_out == ey, "R6", {tag, " y"}, y_out, ey);
    chk(u_out == eu, "R5", {tag, " u"}, u_out, eu);
    if (poke) chk(x_out == ex && y_out == ey && u_out == eu, "R10",
                  {tag, " result unchanged by stray start"}, x_out, ex);
    @(posedge clk); @(negedge clk);
    chk(done == 1'b0, "R9", {tag, " done width"}, done, 0);
    x_init = 8'h5A; y_init = 8'hA5; u_init = 8'h3C;
    repeat (4) begin @(posedge clk); @(negedge clk); end
    chk(x_out == ex && y_out == ey && u_out == eu, "R9",
        {tag, " final state held"}, y_out, ey);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; start = 1'b0;
    a_lim = '0; step = '0; x_init = '0; y_init = '0; u_init = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R1", "done in reset", done, 0);
    chk(x_out == 0 && y_out == 0 && u_out == 0, "R1", "outputs in reset", x_out, 0);
    rst_n = 1'b1;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    chk(x_out == 0 && y_out == 0 && u_out == 0 && !done, "R1",
        "outputs after release", y_out, 0);
  endtask

  task automatic test_idle();
    bit seen_done = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      x_init = 8'(i * 37); y_init = 8'(i * 11); u_init = 8'(200 - i);
      a_lim = 8'd250; step = 8'd3;
      @(posedge clk); @(negedge clk);
      if (done) seen_done = 1;
    end
    chk(!seen_done, "R2", "no done while idle", seen_done, 0);
    chk(x_out == 0 && y_out == 0 && u_out == 0, "R2", "outputs idle", u_out, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_idle();
    // R3: x equal to the limit, no step runs
    run_case(8'd50, 8'd7, 8'd9, 8'd50, 8'd4, "R3 no-step equal", 1'b0);
    // R3: x above the limit
    run_case(8'd90, 8'd1, 8'd2, 8'd20, 8'd4, "R3 no-step above", 1'b0);
    // R7: small coupled run, three steps
    run_case(8'd0, 8'd5, 8'd7, 8'd3, 8'd1, "R7 three steps", 1'b0);
    // R3: unsigned limit above 127, four steps
    run_case(8'd10, 8'd20, 8'd30, 8'd200, 8'd50, "R3 unsigned limit", 1'b0);
    // R4 wrap: 200 -> 4 -> 64 -> 124 -> 184 -> 244
    run_case(8'd200, 8'd9, 8'd250, 8'd230, 8'd60, "R4 wrap", 1'b0);
    // R10/R11: stray start during the run
    run_case(8'd1, 8'd3, 8'd4, 8'd9, 8'd2, "R10 busy start", 1'b1);
    // R11: single step, exercises the registered compare on exit
    run_case(8'd99, 8'd128, 8'd255, 8'd100, 8'd1, "R11 one step", 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule